// File: doc/BRIEF.md
# Four-Cache MESI Line State Tracker

This block keeps the coherence state of one cache line in every cache on a shared snooping bus. It takes one processor reference at a time, either a read or a write from a given cache. For each reference it works out the next state of every cache together, so the snoop side effects are included: invalidation of other copies, and the write-back of a dirty owner. It reports the new state of all caches and the bus actions the reference needs.

It is meant as a coherence reference model or a bus-side state engine next to a group of caches. Data, tags, replacement and bus arbitration stay outside the block. The cache count is a parameter with a default of four. States are encoded Invalid=00, Shared=01, Exclusive=10, Modified=11. The state vector is packed with cache i in bits [2i+1:2i].

Top module: `mesi_line_tracker`

## Requirements
- R1: While reset is asserted, and after it, every cache reads Invalid (state_vec all zero), resp_valid is 0 and all four bus flags are 0.
- R2: A read by a cache in Invalid while no other cache holds the line leaves the requester in Exclusive (10) and raises bus_rd only.
- R3: A read by a cache in Invalid while other caches hold the line in Shared or Exclusive moves the requester and every holder to Shared (01) and raises bus_rd without mem_wb.
- R4: A read by a cache in Invalid while another cache holds Modified moves the owner and the requester to Shared, leaves the remaining caches Invalid, and raises bus_rd together with mem_wb.
- R5: A write by a cache in Invalid leaves the writer in Modified (11) and all other caches Invalid, raises bus_rdx, and also raises mem_wb when another cache held Modified.
- R6: A write by a cache in Shared leaves the writer in Modified and all other caches Invalid, and raises bus_inv only.
- R7: A write by a cache in Exclusive moves it to Modified with no bus flag raised.
- R8: A read or write by a cache in Modified, and a read by a cache in Shared or Exclusive, changes no state and raises no bus flag.
- R9: req_ready is 1 whenever reset is released. An accepted reference (req_valid and req_ready high at a rising edge) updates state_vec and pulses resp_valid with the bus flags in the next cycle. With no reference accepted, state_vec holds and resp_valid stays 0.
- R10: At most one of bus_rd, bus_rdx and bus_inv is high at any time, and mem_wb is high only with bus_rd or bus_rdx.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A reference is offered |
| req_ready | output | 1 | The tracker can take a reference |
| req_cpu | input | $clog2(N_CACHE) | Index of the requesting cache |
| req_write | input | 1 | 1 = write, 0 = read |
| resp_valid | output | 1 | One-cycle pulse: the result of the last accepted reference is on the outputs |
| state_vec | output | 2*N_CACHE | Current state of every cache, two bits per cache |
| bus_rd | output | 1 | The reference needed a shared bus read |
| bus_rdx | output | 1 | The reference needed a read-for-ownership |
| bus_inv | output | 1 | The reference needed an invalidate broadcast |
| mem_wb | output | 1 | A Modified owner writes the line back to memory |

## Verification
The bench builds the tracker with the default N_CACHE=4. With four caches a sequence can show every mix of holders: an owner being demoted while a third cache stays Invalid, and three sharers being wiped by a single write. The vector walk covers each transition class. It includes a Modified line passed from cache to cache by write misses. A second pass after reset reaches Exclusive-to-Modified, which is only possible with no other holder.

// File: rtl/mesi_line_tracker.sv
module mesi_line_tracker #(
  parameter int N_CACHE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [$clog2(N_CACHE)-1:0] req_cpu,
  input  logic                       req_write,
  output logic                       resp_valid,
  output logic [2*N_CACHE-1:0]       state_vec,
  output logic                       bus_rd,
  output logic                       bus_rdx,
  output logic                       bus_inv,
  output logic                       mem_wb
);
  localparam int IW = $clog2(N_CACHE);
  localparam int CW = $clog2(N_CACHE + 1);
  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11;

  logic [N_CACHE-1:0][1:0] st, nxt;
  logic [1:0] own;
  logic       hold, m_other, f_rd, f_rdx, f_inv, f_wb;
  logic       take;

  assign req_ready = rst_n;
  assign take      = req_valid && req_ready;
  assign state_vec = st;
  assign own       = st[req_cpu];

  always_comb begin
    nxt = st;
    hold = 1'b0; m_other = 1'b0;
    f_rd = 1'b0; f_rdx = 1'b0; f_inv = 1'b0; f_wb = 1'b0;
    for (int i = 0; i < N_CACHE; i++) begin
      if (IW'(i) != req_cpu) begin
        if (st[i] != ST_I) hold = 1'b1;
        if (st[i] == ST_M) m_other = 1'b1;
      end
    end
    if (!req_write) begin
      if (own == ST_I) begin
        f_rd = 1'b1;
        f_wb = m_other;
        if (hold) begin
          nxt[req_cpu] = ST_S;
          for (int i = 0; i < N_CACHE; i++)
            if (IW'(i) != req_cpu && st[i] != ST_I) nxt[i] = ST_S;
        end else begin
          nxt[req_cpu] = ST_E;
        end
      end
    end else if (own != ST_M) begin
      if (own == ST_S) f_inv = 1'b1;
      if (own == ST_I) begin
        f_rdx = 1'b1;
        f_wb  = m_other;
      end
      for (int i = 0; i < N_CACHE; i++)
        if (IW'(i) != req_cpu) nxt[i] = ST_I;
      nxt[req_cpu] = ST_M;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= '0;
      resp_valid <= 1'b0;
      bus_rd     <= 1'b0;
      bus_rdx    <= 1'b0;
      bus_inv    <= 1'b0;
      mem_wb     <= 1'b0;
    end else begin
      resp_valid <= take;
      bus_rd     <= take && f_rd;
      bus_rdx    <= take && f_rdx;
      bus_inv    <= take && f_inv;
      mem_wb     <= take && f_wb;
      if (take) st <= nxt;
    end
  end

  logic [CW-1:0] n_live, n_mod;
  always_comb begin
    n_live = '0; n_mod = '0;
    for (int i = 0; i < N_CACHE; i++) begin
      if (st[i] != ST_I) n_live = n_live + 1'b1;
      if (st[i] == ST_M) n_mod  = n_mod + 1'b1;
    end
  end

  p_bus_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_rdx, bus_inv}));
  p_wb_with_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb |-> (bus_rd || bus_rdx));
  p_resp_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> resp_valid);
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (!resp_valid && $stable(state_vec)));
  p_writer_modified_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write) |=> (st[$past(req_cpu)] == ST_M && n_live == CW'(1)));
  p_single_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (n_mod != '0) |-> (n_mod == CW'(1) && n_live == CW'(1)));
endmodule

// File: tb/mesi_line_tracker_tb.sv
module mesi_line_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_cpu = '0;
  logic req_write = 1'b0;
  logic resp_valid;
  logic [7:0] state_vec;
  logic bus_rd, bus_rdx, bus_inv, mem_wb;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mesi_line_tracker #(.N_CACHE(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cpu(req_cpu), .req_write(req_write), .resp_valid(resp_valid),
    .state_vec(state_vec), .bus_rd(bus_rd), .bus_rdx(bus_rdx),
    .bus_inv(bus_inv), .mem_wb(mem_wb));

  // {cpu, write, expected state_vec, expected {rd,rdx,inv,wb}}
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'h02, 4'b1000},  // R2
    {2'd1, 1'b0, 8'h05, 4'b1000},  // R3
    {2'd2, 1'b0, 8'h15, 4'b1000},  // R3
    {2'd3, 1'b1, 8'hC0, 4'b0100},  // R5
    {2'd0, 1'b0, 8'h41, 4'b1001},  // R4
    {2'd0, 1'b0, 8'h41, 4'b0000},  // R8
    {2'd3, 1'b1, 8'hC0, 4'b0010},  // R6
    {2'd3, 1'b0, 8'hC0, 4'b0000},  // R8
    {2'd3, 1'b1, 8'hC0, 4'b0000},  // R8
    {2'd1, 1'b1, 8'h0C, 4'b0101},  // R5
    {2'd1, 1'b0, 8'h0C, 4'b0000},  // R8
    {2'd2, 1'b0, 8'h14, 4'b1001},  // R4
    {2'd2, 1'b1, 8'h30, 4'b0010},  // R6
    {2'd0, 1'b1, 8'h03, 4'b0101},  // R5
    {2'd0, 1'b0, 8'h03, 4'b0000}   // R8
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] cpu, logic wr);
    @(negedge clk);
    req_valid = 1'b1; req_cpu = cpu; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [15:0] outs();
    return {3'b0, resp_valid, bus_rd, bus_rdx, bus_inv, mem_wb, state_vec};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", outs(), 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", outs(), 16'h0000);
    check("R9 ready", {15'b0, req_ready}, 16'h0001);

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k][14:13], VEC[k][12]);
      check($sformatf("R2-R8 vector %0d", k), outs(),
            {3'b0, 1'b1, VEC[k][3:0], VEC[k][11:4]});
    end

    @(negedge clk);
    check("R9 idle no pulse", outs(), 16'h0003);
    req_cpu = 2'd2; req_write = 1'b1;
    @(negedge clk);
    check("R9 no valid no change", outs(), 16'h0003);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 re-reset", outs(), 16'h0000);
    issue(2'd2, 1'b0);
    check("R2 exclusive", outs(), {3'b0, 1'b1, 4'b1000, 8'h20});
    issue(2'd2, 1'b0);
    check("R8 read hit E", outs(), {3'b0, 1'b1, 4'b0000, 8'h20});
    issue(2'd2, 1'b1);
    check("R7 silent upgrade", outs(), {3'b0, 1'b1, 4'b0000, 8'h30});
    issue(2'd1, 1'b0);
    check("R4 owner demoted", outs(), {3'b0, 1'b1, 4'b1001, 8'h14});
    issue(2'd0, 1'b1);
    check("R5 miss wipes sharers", outs(), {3'b0, 1'b1, 4'b0100, 8'h03});
    check("R10 one bus flag", {15'b0, $countones({bus_rd, bus_rdx, bus_inv}) <= 1}, 16'h0001);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule